// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block receives message-signalled interrupts for up to 256 vectors and folds them into one level-sensitive interrupt line for a processor. A remote agent raises vector `n` by writing the value `n` to a single doorbell register through an inbound write port. The write sets a pending bit for that vector. Software sees the pending bits as eight 32-bit status words on a simple 32-bit register bus. It acknowledges a vector by writing a one to its status bit. It masks and unmasks vectors through eight 32-bit enable words, which read back exactly as written.

The interrupt output is a register. It goes high one cycle after any vector is both pending and enabled. It stays high until every such vector is either acknowledged or masked. The doorbell offset is also decoded on the register bus, so software can raise a vector itself, for example when testing.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0. `irq_out` is 0, and every status and enable word reads as 0.
- R2: An inbound write (`in_wr`) to offset 0x7C whose data `n` is below 256 sets pending bit `n mod 32` of the status word at offset 0x80 + 4*(n/32).
- R3: An inbound write whose data is 256 or more changes no pending bit. An inbound write to any offset other than 0x7C also changes no pending bit.
- R4: A bus write to a status word clears each pending bit whose data bit is 1. Each pending bit whose data bit is 0 keeps its value.
- R5: A bus write to offset 0xA0 + 4*k stores the data as enable word k, with the same vector-to-bit mapping as status. A later read returns the stored value, and writing 0 masks all 32 vectors of that word.
- R6: A doorbell write sets the pending bit whether or not the vector is enabled.
- R7: If a doorbell set and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_out` equals, one cycle later, the OR over all vectors of (pending AND enable).
- R9: `cpu_rdata` is valid in the cycle after `cpu_rd` is sampled and is 0 in every other cycle. Reads of offsets outside the status and enable words return 0.
- R10: A bus write to offset 0x7C with data below 256 raises that vector in the same way as an inbound doorbell write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr | input | 1 | Inbound write strobe from the message side |
| in_addr | input | 8 | Inbound write byte offset |
| in_data | input | 32 | Inbound write data; the vector number at the doorbell offset |
| cpu_wr | input | 1 | Register bus write strobe |
| cpu_rd | input | 1 | Register bus read strobe |
| cpu_addr | input | 8 | Register bus byte offset |
| cpu_wdata | input | 32 | Register bus write data |
| cpu_rdata | output | 32 | Register bus read data, one cycle after the read strobe |
| irq_out | output | 1 | Level interrupt: some vector is pending and enabled |

## Verification
A corrupted pending or enable bit shows up in two places. The status or enable word that holds it reads back wrong one cycle after the read. If the bit also decides whether some vector is both pending and enabled, `irq_out` is wrong one cycle after the bit changes. Because of this, the bench checks the interrupt line after every step that can change it, not only at the end. Each test also reads back the exact word it touched. This exposes a set or clear that landed on the wrong bit or word, a lost acknowledge race and a doorbell value that should have been filtered.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;

    localparam int NUM_VEC   = 256;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int VIDX_W    = $clog2(NUM_VEC);
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'hA0;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_DOORBELL,
        RGN_STATUS,
        RGN_ENABLE
    } region_e;

    typedef struct packed {
        region_e             rgn;
        logic [WIDX_W-1:0]   word;
    } reg_sel_t;

    typedef struct packed {
        logic                valid;
        logic [VIDX_W-1:0]   vec;
    } vec_req_t;

    // Interpret doorbell data as a vector number; out-of-range values are dropped.
    function automatic vec_req_t vec_parse(input logic [DATA_W-1:0] d);
        vec_req_t r;
        r.valid = ((d >> VIDX_W) == '0);
        r.vec   = d[VIDX_W-1:0];
        return r;
    endfunction

    function automatic logic [NUM_VEC-1:0] vec_onehot(input vec_req_t r);
        logic [NUM_VEC-1:0] m;
        m = '0;
        if (r.valid) m[r.vec] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_dbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DB_OFS   = OFS_DOORBELL,
    parameter logic [ADDR_W-1:0] STAT_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] EN_OFS   = OFS_ENABLE
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(NUM_WORDS * 4);

    logic [ADDR_W-1:0] stat_off;
    logic [ADDR_W-1:0] en_off;
    logic              aligned;

    always_comb begin
        stat_off = addr - STAT_OFS;
        en_off   = addr - EN_OFS;
        aligned  = (addr[1:0] == 2'b00);
        sel.rgn  = RGN_NONE;
        sel.word = '0;
        if (addr == DB_OFS) begin
            sel.rgn = RGN_DOORBELL;
        end else if (aligned && addr >= STAT_OFS && stat_off < BANK_SPAN) begin
            sel.rgn  = RGN_STATUS;
            sel.word = stat_off[2 +: WIDX_W];
        end else if (aligned && addr >= EN_OFS && en_off < BANK_SPAN) begin
            sel.rgn  = RGN_ENABLE;
            sel.word = en_off[2 +: WIDX_W];
        end
    end

endmodule

// File: rtl/msi_word_slice.sv
module msi_word_slice
    import msi_dbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_bits,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic              en_we,
    input  logic [WORD_W-1:0] en_wdata,
    output logic [WORD_W-1:0] pend,
    output logic [WORD_W-1:0] en
);

    // Clear is applied first, then set, so a coincident doorbell survives.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~clr_bits) | set_bits;
            if (en_we) en <= en_wdata;
        end
    end

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_dbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DB_OFS   = OFS_DOORBELL,
    parameter logic [ADDR_W-1:0] STAT_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] EN_OFS   = OFS_ENABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_wr,
    input  logic [7:0]        in_addr,
    input  logic [31:0]       in_data,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              irq_out
);

    reg_sel_t           in_sel;
    reg_sel_t           cpu_sel;
    vec_req_t           in_req;
    vec_req_t           cpu_req;
    logic [NUM_VEC-1:0] set_all;
    logic [NUM_VEC-1:0] pending_flat;
    logic [NUM_VEC-1:0] enable_flat;
    logic [DATA_W-1:0]  rd_mux;

    msi_reg_decode #(.DB_OFS(DB_OFS), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)) u_in_dec (
        .addr (in_addr),
        .sel  (in_sel)
    );

    msi_reg_decode #(.DB_OFS(DB_OFS), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)) u_cpu_dec (
        .addr (cpu_addr),
        .sel  (cpu_sel)
    );

    always_comb begin
        in_req        = vec_parse(in_data);
        in_req.valid  = in_req.valid & in_wr & (in_sel.rgn == RGN_DOORBELL);
        cpu_req       = vec_parse(cpu_wdata);
        cpu_req.valid = cpu_req.valid & cpu_wr & (cpu_sel.rgn == RGN_DOORBELL);
        set_all       = vec_onehot(in_req) | vec_onehot(cpu_req);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] clr_w;
        logic              en_we_w;
        logic [WORD_W-1:0] pend_w;
        logic [WORD_W-1:0] en_w;

        always_comb begin
            clr_w   = (cpu_wr && cpu_sel.rgn == RGN_STATUS && cpu_sel.word == WIDX_W'(w))
                      ? cpu_wdata : '0;
            en_we_w = cpu_wr && cpu_sel.rgn == RGN_ENABLE && cpu_sel.word == WIDX_W'(w);
        end

        msi_word_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .set_bits (set_all[w*WORD_W +: WORD_W]),
            .clr_bits (clr_w),
            .en_we    (en_we_w),
            .en_wdata (cpu_wdata),
            .pend     (pend_w),
            .en       (en_w)
        );

        assign pending_flat[w*WORD_W +: WORD_W] = pend_w;
        assign enable_flat[w*WORD_W +: WORD_W]  = en_w;
    end

    always_comb begin
        case (cpu_sel.rgn)
            RGN_STATUS: rd_mux = pending_flat[cpu_sel.word*WORD_W +: WORD_W];
            RGN_ENABLE: rd_mux = enable_flat[cpu_sel.word*WORD_W +: WORD_W];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
            irq_out   <= 1'b0;
        end else begin
            cpu_rdata <= cpu_rd ? rd_mux : '0;
            irq_out   <= |(pending_flat & enable_flat);
        end
    end

endmodule

// File: rtl/msi_doorbell_chk.sv
module msi_doorbell_chk
    import msi_dbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DB_OFS = OFS_DOORBELL,
    parameter logic [ADDR_W-1:0] EN_OFS = OFS_ENABLE
) (
    input logic               clk,
    input logic               rst,
    input logic               in_wr,
    input logic [7:0]         in_addr,
    input logic [31:0]        in_data,
    input logic               cpu_wr,
    input logic               cpu_rd,
    input logic [7:0]         cpu_addr,
    input logic [31:0]        cpu_wdata,
    input logic [31:0]        cpu_rdata,
    input logic               irq_out,
    input logic [NUM_VEC-1:0] pending_flat,
    input logic [NUM_VEC-1:0] enable_flat
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_out && pending_flat == '0 && enable_flat == '0));

    a_r2_doorbell_sets: assert property (@(posedge clk) disable iff (rst)
        (in_wr && in_addr == DB_OFS && in_data < 32'(NUM_VEC))
        |=> pending_flat[$past(in_data[VIDX_W-1:0])]);

    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        ($countones(pending_flat) > $past($countones(pending_flat)))
        |-> $past(in_wr || cpu_wr));

    a_r5_enable_store: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == EN_OFS)
        |=> enable_flat[WORD_W-1:0] == $past(cpu_wdata));

    a_r8_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        irq_out == $past(|(pending_flat & enable_flat)));

    a_r9_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(cpu_rd) |-> cpu_rdata == '0);

endmodule

bind msi_doorbell_ctrl msi_doorbell_chk #(.DB_OFS(DB_OFS), .EN_OFS(EN_OFS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_wr        (in_wr),
    .in_addr      (in_addr),
    .in_data      (in_data),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .irq_out      (irq_out),
    .pending_flat (pending_flat),
    .enable_flat  (enable_flat)
);

// File: tb/tb_msi_doorbell_ctrl.sv
`timescale 1ns/1ps
module tb_msi_doorbell_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_wr = 1'b0;
    logic [7:0]  in_addr = '0;
    logic [31:0] in_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_pend [8];
    logic [31:0] m_en   [8];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    msi_doorbell_ctrl dut (
        .clk(clk), .rst(rst),
        .in_wr(in_wr), .in_addr(in_addr), .in_data(in_data),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_out(irq_out)
    );

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int w = 0; w < 8; w++) r |= |(m_pend[w] & m_en[w]);
        return r;
    endfunction

    task automatic model_set(input logic [31:0] d);
        if (d < 32'd256) m_pend[d[7:5]][d[4:0]] = 1'b1;
    endtask

    task automatic model_cpu_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h7C) model_set(d);
        else if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 2'b00) m_pend[a[4:2]] &= ~d;
        else if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 2'b00) m_en[a[4:2]] = d;
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        model_cpu_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic in_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        in_wr = 1'b1; in_addr = a; in_data = d;
        if (a == 8'h7C) model_set(d);
        @(negedge clk);
        in_wr = 1'b0;
    endtask

    // Inbound doorbell and status clear in the same cycle (R7).
    task automatic collide(input logic [31:0] vec, input logic [7:0] a, input logic [31:0] mask);
        @(negedge clk);
        in_wr = 1'b1; in_addr = 8'h7C; in_data = vec;
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = mask;
        model_cpu_write(a, mask);
        model_set(vec);
        @(negedge clk);
        in_wr = 1'b0; cpu_wr = 1'b0;
    endtask

    // Driver: issue a read and push the scoreboard expectation.
    task automatic cpu_read(input logic [7:0] a, input string tag);
        logic [31:0] e;
        e = '0;
        if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 2'b00) e = m_pend[a[4:2]];
        else if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 2'b00) e = m_en[a[4:2]];
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk);
        total++;
        if (irq_out !== model_irq()) begin
            bad++;
            $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, model_irq());
        end
    endtask

    // Monitor: pop and compare on every cycle that follows a sampled read.
    initial begin
        bit rd_seen;
        forever begin
            @(posedge clk);
            rd_seen = cpu_rd;
            @(negedge clk);
            if (rd_seen) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R9 read with no expectation actual=%h expected=none", cpu_rdata);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cpu_rdata !== e) begin
                        bad++;
                        $display("FAIL %s rdata actual=%h expected=%h", t, cpu_rdata, e);
                    end
                end
            end else if (!rst) begin
                total++;
                if (cpu_rdata !== 32'h0) begin
                    bad++;
                    $display("FAIL R9 idle rdata actual=%h expected=00000000", cpu_rdata);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) begin m_pend[w] = '0; m_en[w] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_irq("R1");
        for (int w = 0; w < 8; w++) begin
            cpu_read(8'h80 + 8'(4*w), "R1");
            cpu_read(8'hA0 + 8'(4*w), "R1");
        end

        // R5: enable read-back, then mask everything
        for (int w = 0; w < 8; w++) cpu_write(8'hA0 + 8'(4*w), 32'hA5C3_0F00 ^ 32'(w * 32'h0101_0101));
        for (int w = 0; w < 8; w++) cpu_read(8'hA0 + 8'(4*w), "R5");
        for (int w = 0; w < 8; w++) cpu_write(8'hA0 + 8'(4*w), 32'h0);
        for (int w = 0; w < 8; w++) cpu_read(8'hA0 + 8'(4*w), "R5");
        check_irq("R5");

        // R2/R6: doorbells while masked set pending, irq stays low
        in_write(8'h7C, 32'd0);
        in_write(8'h7C, 32'd31);
        in_write(8'h7C, 32'd32);
        in_write(8'h7C, 32'd100);
        in_write(8'h7C, 32'd255);
        check_irq("R6");
        cpu_read(8'h80, "R2");
        cpu_read(8'h84, "R2");
        cpu_read(8'h8C, "R6");
        cpu_read(8'h9C, "R2");

        // R3: out-of-range data and wrong offsets are dropped
        in_write(8'h7C, 32'd256);
        in_write(8'h7C, 32'h0001_0005);
        in_write(8'h80, 32'd5);
        in_write(8'h78, 32'd6);
        for (int w = 0; w < 8; w++) cpu_read(8'h80 + 8'(4*w), "R3");

        // R10: bus-side doorbell
        cpu_write(8'h7C, 32'd200);
        cpu_read(8'h98, "R10");

        // R8: enabling a pending vector raises irq one cycle later
        cpu_write(8'hAC, 32'h0000_0010);
        check_irq("R8");
        cpu_write(8'hAC, 32'h0);
        check_irq("R8");
        cpu_write(8'hAC, 32'h0000_0010);

        // R4: write-0 leaves status, write-1 clears
        cpu_write(8'h8C, 32'h0);
        cpu_read(8'h8C, "R4");
        check_irq("R4");
        cpu_write(8'h8C, 32'h0000_0010);
        cpu_read(8'h8C, "R4");
        check_irq("R8");
        cpu_write(8'h80, 32'h8000_0000);
        cpu_read(8'h80, "R4");

        // R7: set and clear of vector 64 coincide, plus a clear of another bit
        in_write(8'h7C, 32'd65);
        collide(32'd64, 8'h88, 32'h0000_0003);
        cpu_read(8'h88, "R7");
        cpu_write(8'hA8, 32'h0000_0001);
        check_irq("R7");

        // R9: unmapped and doorbell offsets read as zero
        cpu_read(8'h10, "R9");
        cpu_read(8'h7C, "R9");
        cpu_read(8'hC0, "R9");
        cpu_read(8'h82, "R9");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule